// File: doc/BRIEF.md
# Standby Mode Sequencer

This block moves a microcontroller core between normal run and three low-power modes: sleep, stop and clock mode. Firmware requests a mode by writing a standby control byte. The block accepts the write only when the clock system and the interrupt state allow it. While a low-power mode is active, the block drives clock enables for the CPU, the peripherals, the low-speed tick logic and the main oscillator. It also drives two pin controls, one to hold the pins and one to float them.

The block leaves a low-power mode in one of two ways. A peripheral interrupt of sufficient priority returns it straight to run. The block then reports through a wake pulse whether the CPU will vector to the interrupt or resume at the next instruction. An external reset also ends a low-power mode. If the main oscillator was stopped, a reset first passes through a stabilization wait whose length is set by a 2-bit select. Only after that wait does the block issue a one-cycle start pulse for the reset sequence.

Top module: `standby_ctrl`

## Requirements
- R1: The block decodes a write in run mode from three bits: wrData[7] (stop), wrData[6] (sleep) and wrData[3] (clock). The pattern {7,6,3}=100 enters stop, 010 enters sleep, 001 enters clock mode and 000 stays in run. modeState encodes run=0, sleep=1, stop=2, clock=3, wait=4.
- R2: Every other pattern of bits 7, 6 and 3 is prohibited. Such a write is a no-op and the block stays in run.
- R3: A clock-mode request is refused while clkSelSub=1.
- R4: Every mode-entry request is refused while irqReq=1 in the write cycle, or while clkSwitchDone=0.
- R5: The clock enables follow the mode. Run: all four on. Sleep: CPU off, the others on. Stop: all off. Clock mode: only tickClkEn on. Wait: only oscEn on.
- R6: On clock-mode entry, the block latches wrData[5]. A 0 raises pinHold and a 1 raises pinHiZ for as long as clock mode lasts. Stop raises pinHold. Run, sleep and wait raise neither. The two are never high together.
- R7: In sleep, stop or clock mode, irqReq with irqLevel 00, 01 or 10 returns the block to run on the next edge and raises wakePulse for one cycle. Level 11 causes no wake.
- R8: At a wake, wakeService=1 exactly when intEnable=1 and irqLevel is numerically below cpuLevel. Otherwise it is 0.
- R9: extReset in stop or clock mode enters wait (4). The block stays in wait for 2^E cycles, where E is the exponent that waitSel selects (defaults 2, 12, 15, 17). It then raises resetSeqStart for one cycle and returns to run.
- R10: extReset in run or sleep raises resetSeqStart on the next cycle with the block in run. extReset during wait restarts the full count.
- R11: Writes are ignored outside run mode.
- R12: After rstN the block is in run with all enables on, both pin controls low and all pulses low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low power-on reset |
| wrEn | input | 1 | Standby control write strobe |
| wrData | input | 8 | Standby control write data |
| clkSelSub | input | 1 | 1 while the sub clock is selected |
| clkSwitchDone | input | 1 | 0 while a sub-to-main clock switch is in progress |
| waitSel | input | 2 | Oscillator stabilization length select |
| irqReq | input | 1 | Pending peripheral interrupt request |
| irqLevel | input | 2 | Priority level of the pending request (00 highest) |
| intEnable | input | 1 | CPU interrupt-enable flag |
| cpuLevel | input | 2 | Current CPU interrupt level |
| extReset | input | 1 | External reset, synchronous to clk |
| modeState | output | 3 | Current mode code |
| cpuClkEn | output | 1 | CPU clock enable |
| periClkEn | output | 1 | Peripheral clock enable |
| tickClkEn | output | 1 | Prescaler and wake-logic clock enable |
| oscEn | output | 1 | Main oscillator enable |
| pinHold | output | 1 | Hold pins at their last value |
| pinHiZ | output | 1 | Float pins to high impedance |
| wakePulse | output | 1 | One-cycle pulse on an interrupt wake |
| wakeService | output | 1 | With wakePulse: 1 if the interrupt will be serviced |
| resetSeqStart | output | 1 | One-cycle start pulse for the reset sequence |

## Verification
The assertions assume several things about the inputs. All inputs, extReset included, are synchronous to clk. irqLevel is meaningful only while irqReq is high. extReset drops within a cycle or two once the wait has been entered. The stimulus changes every input on the falling edge only. It holds extReset for a single cycle at a time and drops irqReq in the cycle after the sampled edge, so each wake or refusal rule is judged against one request only. The bench runs the wait with a small set of exponents, which keeps the counter rules identical to the default build.

// File: rtl/stby_pkg.sv
package stby_pkg;

  typedef enum logic [2:0] {
    MODE_RUN   = 3'd0,
    MODE_SLEEP = 3'd1,
    MODE_STOP  = 3'd2,
    MODE_CLOCK = 3'd3,
    MODE_WAIT  = 3'd4
  } modeE;

  typedef enum logic [1:0] {
    REQ_NONE,
    REQ_SLEEP,
    REQ_STOP,
    REQ_CLOCK
  } reqE;

  // Strobes from the control FSM into the datapath
  typedef struct packed {
    logic loadWait;
    logic latchPin;
  } strobeT;

endpackage

// File: rtl/stby_datapath.sv
module stby_datapath
  import stby_pkg::*;
#(
  parameter int WAIT_EXP0 = 2,
  parameter int WAIT_EXP1 = 12,
  parameter int WAIT_EXP2 = 15,
  parameter int WAIT_EXP3 = 17
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] reqBits,   // {stop, sleep, clock}
  input  logic       pinBit,
  input  logic [1:0] waitSel,
  input  strobeT     strobes,
  output reqE        reqKind,
  output logic       pinFloat,
  output logic       waitZero
);

  localparam int EXPS [4] = '{WAIT_EXP0, WAIT_EXP1, WAIT_EXP2, WAIT_EXP3};
  localparam int MAX01  = (WAIT_EXP0 > WAIT_EXP1) ? WAIT_EXP0 : WAIT_EXP1;
  localparam int MAX23  = (WAIT_EXP2 > WAIT_EXP3) ? WAIT_EXP2 : WAIT_EXP3;
  localparam int MAXEXP = (MAX01 > MAX23) ? MAX01 : MAX23;
  localparam int CNT_W  = MAXEXP + 1;

  logic [CNT_W-1:0] waitCnt;
  logic [CNT_W-1:0] reloadVal;
  logic [31:0]      reloadFull;

  // Request decode: only the three one-hot patterns are legal
  always_comb begin
    case (reqBits)
      3'b100:  reqKind = REQ_STOP;
      3'b010:  reqKind = REQ_SLEEP;
      3'b001:  reqKind = REQ_CLOCK;
      default: reqKind = REQ_NONE;
    endcase
  end

  // Load value is the stabilization length minus one
  always_comb begin
    reloadFull = (32'd1 << EXPS[waitSel]) - 32'd1;
    reloadVal  = reloadFull[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      waitCnt <= '0;
    end else if (strobes.loadWait) begin
      waitCnt <= reloadVal;
    end else if (waitCnt != '0) begin
      waitCnt <= waitCnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pinFloat <= 1'b0;
    end else if (strobes.latchPin) begin
      pinFloat <= pinBit;
    end
  end

  assign waitZero = (waitCnt == '0);

endmodule

// File: rtl/stby_ctrl.sv
module stby_ctrl
  import stby_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  reqE        reqKind,
  input  logic       clkSelSub,
  input  logic       clkSwitchDone,
  input  logic       irqReq,
  input  logic [1:0] irqLevel,
  input  logic       intEnable,
  input  logic [1:0] cpuLevel,
  input  logic       extReset,
  input  logic       waitZero,
  input  logic       pinFloat,
  output strobeT     strobes,
  output modeE       mode,
  output logic       cpuClkEn,
  output logic       periClkEn,
  output logic       tickClkEn,
  output logic       oscEn,
  output logic       pinHold,
  output logic       pinHiZ,
  output logic       wakePulse,
  output logic       wakeService,
  output logic       resetSeqStart
);

  modeE nextMode;
  logic nextWake, nextSvc, nextStart;
  logic wakeHit, acceptWr;

  assign wakeHit  = irqReq && (irqLevel != 2'b11);
  assign acceptWr = wrEn && (reqKind != REQ_NONE) && !irqReq && clkSwitchDone
                    && !((reqKind == REQ_CLOCK) && clkSelSub);

  always_comb begin
    nextMode  = mode;
    strobes   = '0;
    nextWake  = 1'b0;
    nextSvc   = 1'b0;
    nextStart = 1'b0;
    if (extReset) begin
      if (mode == MODE_STOP || mode == MODE_CLOCK || mode == MODE_WAIT) begin
        nextMode         = MODE_WAIT;
        strobes.loadWait = 1'b1;
      end else begin
        nextMode  = MODE_RUN;
        nextStart = 1'b1;
      end
    end else begin
      case (mode)
        MODE_RUN: begin
          if (acceptWr) begin
            case (reqKind)
              REQ_SLEEP: nextMode = MODE_SLEEP;
              REQ_STOP:  nextMode = MODE_STOP;
              default:   nextMode = MODE_CLOCK;
            endcase
            strobes.latchPin = (reqKind == REQ_CLOCK);
          end
        end
        MODE_SLEEP, MODE_STOP, MODE_CLOCK: begin
          if (wakeHit) begin
            nextMode = MODE_RUN;
            nextWake = 1'b1;
            nextSvc  = intEnable && (irqLevel < cpuLevel);
          end
        end
        MODE_WAIT: begin
          if (waitZero) begin
            nextMode  = MODE_RUN;
            nextStart = 1'b1;
          end
        end
        default: nextMode = MODE_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mode          <= MODE_RUN;
      wakePulse     <= 1'b0;
      wakeService   <= 1'b0;
      resetSeqStart <= 1'b0;
    end else begin
      mode          <= nextMode;
      wakePulse     <= nextWake;
      wakeService   <= nextSvc;
      resetSeqStart <= nextStart;
    end
  end

  // Per-mode enables and pin controls
  always_comb begin
    cpuClkEn  = 1'b0;
    periClkEn = 1'b0;
    tickClkEn = 1'b0;
    oscEn     = 1'b0;
    pinHold   = 1'b0;
    pinHiZ    = 1'b0;
    case (mode)
      MODE_RUN: begin
        cpuClkEn = 1'b1; periClkEn = 1'b1; tickClkEn = 1'b1; oscEn = 1'b1;
      end
      MODE_SLEEP: begin
        periClkEn = 1'b1; tickClkEn = 1'b1; oscEn = 1'b1;
      end
      MODE_STOP:  pinHold = 1'b1;
      MODE_CLOCK: begin
        tickClkEn = 1'b1;
        pinHold   = !pinFloat;
        pinHiZ    = pinFloat;
      end
      MODE_WAIT:  oscEn = 1'b1;
      default: ;
    endcase
  end

endmodule

// File: rtl/standby_ctrl.sv
module standby_ctrl
  import stby_pkg::*;
#(
  parameter int WAIT_EXP0 = 2,
  parameter int WAIT_EXP1 = 12,
  parameter int WAIT_EXP2 = 15,
  parameter int WAIT_EXP3 = 17
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [7:0] wrData,
  input  logic       clkSelSub,
  input  logic       clkSwitchDone,
  input  logic [1:0] waitSel,
  input  logic       irqReq,
  input  logic [1:0] irqLevel,
  input  logic       intEnable,
  input  logic [1:0] cpuLevel,
  input  logic       extReset,
  output logic [2:0] modeState,
  output logic       cpuClkEn,
  output logic       periClkEn,
  output logic       tickClkEn,
  output logic       oscEn,
  output logic       pinHold,
  output logic       pinHiZ,
  output logic       wakePulse,
  output logic       wakeService,
  output logic       resetSeqStart
);

  strobeT strobes;
  reqE    reqKind;
  modeE   mode;
  logic   pinFloat, waitZero;
  logic   unusedBits;

  assign unusedBits = ^{wrData[4], wrData[2:0]};

  stby_datapath #(
    .WAIT_EXP0(WAIT_EXP0), .WAIT_EXP1(WAIT_EXP1),
    .WAIT_EXP2(WAIT_EXP2), .WAIT_EXP3(WAIT_EXP3)
  ) uData (
    .clk      (clk),
    .rstN     (rstN),
    .reqBits  ({wrData[7], wrData[6], wrData[3]}),
    .pinBit   (wrData[5]),
    .waitSel  (waitSel),
    .strobes  (strobes),
    .reqKind  (reqKind),
    .pinFloat (pinFloat),
    .waitZero (waitZero)
  );

  stby_ctrl uCtrl (
    .clk           (clk),
    .rstN          (rstN),
    .wrEn          (wrEn),
    .reqKind       (reqKind),
    .clkSelSub     (clkSelSub),
    .clkSwitchDone (clkSwitchDone),
    .irqReq        (irqReq),
    .irqLevel      (irqLevel),
    .intEnable     (intEnable),
    .cpuLevel      (cpuLevel),
    .extReset      (extReset),
    .waitZero      (waitZero),
    .pinFloat      (pinFloat),
    .strobes       (strobes),
    .mode          (mode),
    .cpuClkEn      (cpuClkEn),
    .periClkEn     (periClkEn),
    .tickClkEn     (tickClkEn),
    .oscEn         (oscEn),
    .pinHold       (pinHold),
    .pinHiZ        (pinHiZ),
    .wakePulse     (wakePulse),
    .wakeService   (wakeService),
    .resetSeqStart (resetSeqStart)
  );

  assign modeState = mode;

endmodule

// File: rtl/stby_checker.sv
module stby_checker (
  input logic       clk,
  input logic       rstN,
  input logic       wrEn,
  input logic [7:0] wrData,
  input logic       clkSelSub,
  input logic       irqReq,
  input logic [1:0] irqLevel,
  input logic       extReset,
  input logic [2:0] modeState,
  input logic       cpuClkEn,
  input logic       periClkEn,
  input logic       oscEn,
  input logic       pinHold,
  input logic       pinHiZ,
  input logic       wakePulse,
  input logic       wakeService,
  input logic       resetSeqStart
);

  logic [2:0] reqBits;
  assign reqBits = {wrData[7], wrData[6], wrData[3]};

  assert_prohibited_noop_R2: assert property (@(posedge clk) disable iff (!rstN)
    (modeState == 3'd0 && wrEn && !extReset &&
     reqBits != 3'b100 && reqBits != 3'b010 && reqBits != 3'b001)
    |=> modeState == 3'd0);

  assert_refuse_sub_R3: assert property (@(posedge clk) disable iff (!rstN)
    (modeState == 3'd0 && wrEn && reqBits == 3'b001 && clkSelSub && !extReset)
    |=> modeState != 3'd3);

  assert_refuse_pending_R4: assert property (@(posedge clk) disable iff (!rstN)
    (modeState == 3'd0 && wrEn && irqReq && !extReset) |=> modeState == 3'd0);

  assert_stop_gated_R5: assert property (@(posedge clk) disable iff (!rstN)
    modeState == 3'd2 |-> (!oscEn && !cpuClkEn && !periClkEn));

  assert_pins_exclusive_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(pinHold && pinHiZ));

  assert_level3_nowake_R7: assert property (@(posedge clk) disable iff (!rstN)
    (modeState == 3'd3 && irqReq && irqLevel == 2'b11 && !extReset)
    |=> (modeState == 3'd3 && !wakePulse));

  assert_service_with_wake_R8: assert property (@(posedge clk) disable iff (!rstN)
    wakeService |-> wakePulse);

  assert_enter_wait_R9: assert property (@(posedge clk) disable iff (!rstN)
    (extReset && (modeState == 3'd2 || modeState == 3'd3)) |=> modeState == 3'd4);

  assert_start_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    (resetSeqStart && !extReset) |=> !resetSeqStart);

  assert_sleep_reset_R10: assert property (@(posedge clk) disable iff (!rstN)
    (extReset && modeState == 3'd1) |=> (resetSeqStart && modeState == 3'd0));

  assert_sleep_ignores_write_R11: assert property (@(posedge clk) disable iff (!rstN)
    (modeState == 3'd1 && !extReset && !irqReq) |=> modeState == 3'd1);

endmodule

bind standby_ctrl stby_checker uChk (
  .clk           (clk),
  .rstN          (rstN),
  .wrEn          (wrEn),
  .wrData        (wrData),
  .clkSelSub     (clkSelSub),
  .irqReq        (irqReq),
  .irqLevel      (irqLevel),
  .extReset      (extReset),
  .modeState     (modeState),
  .cpuClkEn      (cpuClkEn),
  .periClkEn     (periClkEn),
  .oscEn         (oscEn),
  .pinHold       (pinHold),
  .pinHiZ        (pinHiZ),
  .wakePulse     (wakePulse),
  .wakeService   (wakeService),
  .resetSeqStart (resetSeqStart)
);

// File: tb/sim_standby_ctrl.sv
`timescale 1ns/1ps
module sim_standby_ctrl;

  logic       clk = 1'b0;
  logic       rstN, wrEn, clkSelSub, clkSwitchDone, irqReq, intEnable, extReset;
  logic [7:0] wrData;
  logic [1:0] waitSel, irqLevel, cpuLevel;
  logic [2:0] modeState;
  logic       cpuClkEn, periClkEn, tickClkEn, oscEn, pinHold, pinHiZ;
  logic       wakePulse, wakeService, resetSeqStart;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  localparam int EXP_TB [4] = '{2, 3, 4, 5};

  always #4 clk = ~clk;

  standby_ctrl #(.WAIT_EXP0(2), .WAIT_EXP1(3), .WAIT_EXP2(4), .WAIT_EXP3(5)) u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .clkSelSub(clkSelSub), .clkSwitchDone(clkSwitchDone), .waitSel(waitSel),
    .irqReq(irqReq), .irqLevel(irqLevel), .intEnable(intEnable),
    .cpuLevel(cpuLevel), .extReset(extReset), .modeState(modeState),
    .cpuClkEn(cpuClkEn), .periClkEn(periClkEn), .tickClkEn(tickClkEn),
    .oscEn(oscEn), .pinHold(pinHold), .pinHiZ(pinHiZ), .wakePulse(wakePulse),
    .wakeService(wakeService), .resetSeqStart(resetSeqStart)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Expected {cpu, peri, tick, osc} per mode code
  function automatic int enExp(input int m);
    enExp = {28'd0, m == 0, m <= 1, (m <= 1) || (m == 3), (m <= 1) || (m == 4)};
  endfunction

  function automatic int enAct();
    enAct = {28'd0, cpuClkEn, periClkEn, tickClkEn, oscEn};
  endfunction

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; wrEn = 1'b0; wrData = 8'h00; clkSelSub = 1'b0;
    clkSwitchDone = 1'b1; waitSel = 2'd0; irqReq = 1'b0; irqLevel = 2'd0;
    intEnable = 1'b0; cpuLevel = 2'd3; extReset = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic writeReg(input logic [7:0] d, input logic pend);
    wrEn = 1'b1; wrData = d; irqReq = pend; irqLevel = 2'd3;
    @(negedge clk);
    wrEn = 1'b0; irqReq = 1'b0;
  endtask

  // Pulses extReset for one cycle, returns cycles until the start pulse
  task automatic measureWait(output int n);
    extReset = 1'b1;
    @(negedge clk);
    extReset = 1'b0;
    n = 0;
    while (!resetSeqStart && n < 1000) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog all-requirements actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int n;
    int expMode;
    doReset();
    // R12 reset state
    chk("R12", "mode", modeState, 0);
    chk("R12", "enables", enAct(), 15);
    chk("R12", "pins", {pinHold, pinHiZ}, 0);
    chk("R12", "pulses", {wakePulse, wakeService, resetSeqStart}, 0);

    // R1 R2 R3 R4 R5: entry sweep over request bits and gating inputs
    for (int b = 0; b < 8; b++) begin
      for (int sub = 0; sub < 2; sub++) begin
        for (int pend = 0; pend < 2; pend++) begin
          for (int sw = 0; sw < 2; sw++) begin
            doReset();
            clkSelSub = sub[0]; clkSwitchDone = sw[0];
            writeReg({b[2], b[1], 2'b00, b[0], 3'b000}, pend[0]);
            case (b)
              4: expMode = 2;
              2: expMode = 1;
              1: expMode = 3;
              default: expMode = 0;
            endcase
            if (pend == 1 || sw == 0 || (b == 1 && sub == 1)) expMode = 0;
            chk((b == 1 && sub == 1) ? "R3" : (pend == 1 || sw == 0) ? "R4" :
                (expMode == 0 && b != 0) ? "R2" : "R1", "mode after write",
                modeState, expMode);
            chk("R5", "enables", enAct(), enExp(expMode));
          end
        end
      end
    end

    // R6 pin controls
    doReset();
    writeReg(8'h28, 1'b0);
    chk("R6", "clock float pins", {pinHold, pinHiZ}, 1);
    doReset();
    writeReg(8'h08, 1'b0);
    chk("R6", "clock hold pins", {pinHold, pinHiZ}, 2);
    doReset();
    writeReg(8'h80, 1'b0);
    chk("R6", "stop hold pins", {pinHold, pinHiZ}, 2);
    doReset();
    writeReg(8'h40, 1'b0);
    chk("R6", "sleep pins", {pinHold, pinHiZ}, 0);

    // R7 R8 wake sweep
    for (int m = 1; m < 4; m++) begin
      for (int lvl = 0; lvl < 4; lvl++) begin
        for (int ie = 0; ie < 2; ie++) begin
          for (int cl = 0; cl < 4; cl++) begin
            doReset();
            writeReg((m == 1) ? 8'h40 : (m == 2) ? 8'h80 : 8'h08, 1'b0);
            intEnable = ie[0]; cpuLevel = cl[1:0];
            irqReq = 1'b1; irqLevel = lvl[1:0];
            @(negedge clk);
            irqReq = 1'b0;
            if (lvl == 3) begin
              chk("R7", "no wake mode", modeState, m);
              chk("R7", "no wake pulse", wakePulse, 0);
            end else begin
              chk("R7", "wake mode", modeState, 0);
              chk("R7", "wake pulse", wakePulse, 1);
              chk("R8", "service", wakeService, (ie == 1 && lvl < cl) ? 1 : 0);
              @(negedge clk);
              chk("R7", "pulse width", wakePulse, 0);
            end
          end
        end
      end
    end

    // R9 reset wait length per select, from stop and from clock mode
    for (int m = 2; m < 4; m++) begin
      for (int s = 0; s < 4; s++) begin
        doReset();
        waitSel = s[1:0];
        writeReg((m == 2) ? 8'h80 : 8'h08, 1'b0);
        extReset = 1'b1;
        @(negedge clk);
        extReset = 1'b0;
        chk("R9", "wait mode", modeState, 4);
        chk("R5", "wait enables", enAct(), enExp(4));
        n = 0;
        while (!resetSeqStart && n < 1000) begin
          @(negedge clk);
          n++;
        end
        chk("R9", "wait length", n, 1 << EXP_TB[s]);
        chk("R9", "mode after wait", modeState, 0);
        @(negedge clk);
        chk("R9", "start width", resetSeqStart, 0);
      end
    end

    // R10 reset from run and sleep
    doReset();
    measureWait(n);
    chk("R10", "run reset latency", n, 0);
    chk("R10", "run reset mode", modeState, 0);
    doReset();
    writeReg(8'h40, 1'b0);
    measureWait(n);
    chk("R10", "sleep reset latency", n, 0);
    chk("R10", "sleep reset mode", modeState, 0);

    // R10 reset during wait restarts the count
    doReset();
    waitSel = 2'd3;
    writeReg(8'h80, 1'b0);
    extReset = 1'b1;
    @(negedge clk);
    extReset = 1'b0;
    repeat (3) @(negedge clk);
    measureWait(n);
    chk("R10", "restarted wait length", n, 32);

    // R11 writes ignored outside run
    doReset();
    writeReg(8'h40, 1'b0);
    writeReg(8'h80, 1'b0);
    chk("R11", "sleep ignores stop write", modeState, 1);
    writeReg(8'h00, 1'b0);
    chk("R11", "sleep ignores clear write", modeState, 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule